// File: doc/BRIEF.md
# Pseudo-static RAM bus protocol monitor

This block is a passive, synchronous observer for the control side of an asynchronous pseudo-static RAM port. It samples chip select, write strobe, output strobe, both byte-lane enables, the word address and the controller's data-drive enable on every system clock. From these it decodes the bus mode, measures pulse widths and gaps in clock counts, and flags violations of the device's timing and usage rules. It never drives the bus and holds no copy of memory contents.

The same block can sit in silicon beside a memory controller, or next to one in a testbench. Every limit is a parameter in clock cycles. Each check produces a one-cycle hit on its own error bit. Hits are collected into a sticky one-hot register that a separate clear input resets. A saturating counter keeps the total number of violations. The block has no streaming data path, so every pin is a plain level signal. There is no back-pressure.

Top module: `psram_bus_monitor`

## Requirements
- R1: `mode` is a combinational decode of the current inputs. Code 0 (standby) is reported whenever `ce_n` is 1, or whenever `ub_n` and `lb_n` are both 1, regardless of the other strobes. If the chip is selected with a lane enabled and `we_n`=1, `oe_n`=1, the code is 1 (outputs disabled).
- R2: With the chip selected and at least one lane enabled, `we_n`=0 gives a write and otherwise `oe_n`=0 gives a read. The lane code for reads is 2 for both lanes, 3 for the low lane only and 4 for the high lane only. For writes it is 5, 6 and 7 in the same lane order. In a write, `oe_n` has no effect.
- R3: Error bit 0 (contention) is set when `drv_en`=1 in a cycle decoded as a read (codes 2 to 4). `drv_en` in any other mode has no effect.
- R4: Error bit 1 is set in the cycle a write overlap ends, if the overlap lasted fewer than `T_PWE` cycles. The overlap is the cycles with chip selected, `we_n`=0 and any lane enabled. It ends when any of these goes inactive.
- R5: Error bit 2 is set at the end of an overlap if chip select had been low for fewer than `T_SCE` consecutive cycles.
- R6: Error bit 3 is set at the end of an overlap if some lane enable had been low for fewer than `T_BW` consecutive cycles.
- R7: Error bit 4 is set when the address changes between two consecutive read cycles and the previous address had been held in read for fewer than `T_RC` cycles.
- R8: Error bit 5 (abnormal read) is set once a run of `T_ABN` cycles has passed with the chip selected and `we_n`=1, none of them with an address held for at least `T_RC` cycles. The run restarts when an address has been held for `T_RC` cycles, or when chip select stays high for `T_RC` cycles. A shorter high interval, or a write, only pauses the run.
- R9: `err_sticky` is 0 after reset. A set bit stays set until a cycle with `err_clear`=1. A hit in the same cycle as a clear is still latched.
- R10: `viol_count` is 0 after reset. Each cycle it adds the number of error bits hit in that cycle and saturates at 16'hFFFF. `err_clear` does not touch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| ub_n | input | 1 | High byte-lane enable, active low |
| lb_n | input | 1 | Low byte-lane enable, active low |
| addr | input | AW | Word address |
| drv_en | input | 1 | Controller is driving the data pins |
| err_clear | input | 1 | Clears the sticky error register |
| mode | output | 3 | Decoded bus mode code (R1, R2) |
| err_sticky | output | 6 | Sticky one-hot error flags |
| viol_count | output | 16 | Saturating violation total |

## Verification
The bench keeps the fast-grade cycle limits at their defaults (`T_RC`=6, `T_PWE`=4, `T_SCE`=5, `T_BW`=5). It shrinks `T_ABN` from 1500 to 40, so that the abnormal-read run and its restart rules can be exercised in a few hundred cycles. With these values a write overlap can be cut by each of its three signals, one cycle below each limit. The 16-bit counter is driven into saturation with about 66 000 contention hits.

// File: rtl/psram_mon_pkg.sv
package psram_mon_pkg;
  typedef enum logic [2:0] {
    MD_IDLE = 3'd0, MD_NODRV = 3'd1,
    MD_RD_W = 3'd2, MD_RD_L = 3'd3, MD_RD_H = 3'd4,
    MD_WR_W = 3'd5, MD_WR_L = 3'd6, MD_WR_H = 3'd7
  } bus_mode_e;

  localparam int unsigned NUM_ERR    = 6;
  localparam int unsigned E_CONTEND  = 0;
  localparam int unsigned E_WPULSE   = 1;
  localparam int unsigned E_CE2END   = 2;
  localparam int unsigned E_BE2END   = 3;
  localparam int unsigned E_RDADDR   = 4;
  localparam int unsigned E_ABNRD    = 5;

  function automatic logic is_read(bus_mode_e m);
    return (m == MD_RD_W) || (m == MD_RD_L) || (m == MD_RD_H);
  endfunction
endpackage

// File: rtl/psram_mode_decode.sv
module psram_mode_decode
  import psram_mon_pkg::*;
(
  input  logic      ce_n,
  input  logic      we_n,
  input  logic      oe_n,
  input  logic      ub_n,
  input  logic      lb_n,
  output bus_mode_e mode
);
  logic [1:0] lanes;
  assign lanes = {~ub_n, ~lb_n};

  always_comb begin
    mode = MD_IDLE;
    if (!ce_n && lanes != 2'b00) begin
      if (!we_n) begin
        unique case (lanes)
          2'b11:   mode = MD_WR_W;
          2'b01:   mode = MD_WR_L;
          default: mode = MD_WR_H;
        endcase
      end else if (!oe_n) begin
        unique case (lanes)
          2'b11:   mode = MD_RD_W;
          2'b01:   mode = MD_RD_L;
          default: mode = MD_RD_H;
        endcase
      end else begin
        mode = MD_NODRV;
      end
    end
  end
endmodule

// File: rtl/psram_run_cnt.sv
module psram_run_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  output logic [W-1:0] now_v,
  output logic [W-1:0] prev_v
);
  always_comb begin
    if (!active)            now_v = '0;
    else if (prev_v == '1)  now_v = prev_v;
    else                    now_v = prev_v + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_v <= '0;
    else        prev_v <= now_v;
  end
endmodule

// File: rtl/psram_write_timer.sv
module psram_write_timer #(
  parameter int TW    = 12,
  parameter int T_PWE = 4,
  parameter int T_SCE = 5,
  parameter int T_BW  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic ub_n,
  input  logic lb_n,
  output logic err_pulse,
  output logic err_ce,
  output logic err_be
);
  localparam logic [TW-1:0] PWE_C = TW'(T_PWE);
  localparam logic [TW-1:0] SCE_C = TW'(T_SCE);
  localparam logic [TW-1:0] BW_C  = TW'(T_BW);

  logic          any_be, in_wr, wr_end;
  logic [TW-1:0] ce_now, ce_prev, be_now, be_prev, wr_now, wr_prev;

  assign any_be = ~ub_n | ~lb_n;
  assign in_wr  = ~ce_n & ~we_n & any_be;

  psram_run_cnt #(.W(TW)) u_ce_run (.clk(clk), .rst_n(rst_n), .active(~ce_n),
                                    .now_v(ce_now), .prev_v(ce_prev));
  psram_run_cnt #(.W(TW)) u_be_run (.clk(clk), .rst_n(rst_n), .active(any_be),
                                    .now_v(be_now), .prev_v(be_prev));
  psram_run_cnt #(.W(TW)) u_wr_run (.clk(clk), .rst_n(rst_n), .active(in_wr),
                                    .now_v(wr_now), .prev_v(wr_prev));

  assign wr_end    = (wr_prev != '0) && !in_wr;
  assign err_pulse = wr_end && (wr_prev < PWE_C);
  assign err_ce    = wr_end && (ce_prev < SCE_C);
  assign err_be    = wr_end && (be_prev < BW_C);

  logic unused_now;
  assign unused_now = ^{ce_now, be_now, wr_now};
endmodule

// File: rtl/psram_read_watch.sv
module psram_read_watch #(
  parameter int AW    = 17,
  parameter int TW    = 12,
  parameter int T_RC  = 6,
  parameter int T_ABN = 1500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          rd_mode,
  input  logic [AW-1:0] addr,
  output logic          err_rdaddr,
  output logic          err_abn
);
  localparam logic [TW-1:0] RC_C   = TW'(T_RC);
  localparam logic [TW-1:0] ABN_M1 = TW'(T_ABN - 1);

  logic [AW-1:0] addr_q;
  logic          addr_chg, rd_q, seq_en;
  logic [TW-1:0] st_now, st_q, rd_now, age_q, ab_nxt, ab_q, ch_now, ch_prev;

  function automatic logic [TW-1:0] sat_inc(logic [TW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign addr_chg = (addr != addr_q);
  assign seq_en   = ~ce_n & we_n;

  // address hold length, current cycle included
  assign st_now = addr_chg ? TW'(1) : sat_inc(st_q);

  // read hold length at the current address
  always_comb begin
    if (!rd_mode)                 rd_now = '0;
    else if (!rd_q || addr_chg)   rd_now = TW'(1);
    else                          rd_now = sat_inc(age_q);
  end

  psram_run_cnt #(.W(TW)) u_cehi_run (.clk(clk), .rst_n(rst_n), .active(ce_n),
                                      .now_v(ch_now), .prev_v(ch_prev));

  always_comb begin
    ab_nxt = ab_q;
    if (ce_n && ch_now >= RC_C)   ab_nxt = '0;
    else if (seq_en)              ab_nxt = (st_now >= RC_C) ? '0 : sat_inc(ab_q);
  end

  assign err_rdaddr = rd_mode && rd_q && addr_chg && (age_q < RC_C);
  assign err_abn    = seq_en && (st_now < RC_C) && (ab_q == ABN_M1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      st_q   <= '0;
      rd_q   <= 1'b0;
      age_q  <= '0;
      ab_q   <= '0;
    end else begin
      addr_q <= addr;
      st_q   <= st_now;
      rd_q   <= rd_mode;
      age_q  <= rd_now;
      ab_q   <= ab_nxt;
    end
  end

  logic unused_ch;
  assign unused_ch = ^ch_prev;
endmodule

// File: rtl/psram_err_log.sv
module psram_err_log #(
  parameter int NE    = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NE-1:0]    hit,
  input  logic             clear,
  output logic [NE-1:0]    sticky,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W:0] CAP = {1'b0, {CNT_W{1'b1}}};
  logic [CNT_W:0] sum;

  for (genvar i = 0; i < NE; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) sticky[i] <= 1'b0;
      else        sticky[i] <= (sticky[i] & ~clear) | hit[i];
    end
  end

  assign sum = {1'b0, count} + (CNT_W+1)'($countones(hit));

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (sum > CAP)  count <= '1;
    else                 count <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/psram_bus_monitor.sv
module psram_bus_monitor
  import psram_mon_pkg::*;
#(
  parameter int AW    = 17,
  parameter int T_RC  = 6,
  parameter int T_PWE = 4,
  parameter int T_SCE = 5,
  parameter int T_BW  = 5,
  parameter int T_ABN = 1500,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               ub_n,
  input  logic               lb_n,
  input  logic [AW-1:0]      addr,
  input  logic               drv_en,
  input  logic               err_clear,
  output logic [2:0]         mode,
  output logic [NUM_ERR-1:0] err_sticky,
  output logic [CNT_W-1:0]   viol_count
);
  localparam int TW = $clog2(T_ABN + T_RC + T_PWE + T_SCE + T_BW + 2);

  bus_mode_e          mode_e;
  logic               rd_mode;
  logic [NUM_ERR-1:0] hit;

  psram_mode_decode u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .mode(mode_e)
  );

  assign mode    = mode_e;
  assign rd_mode = is_read(mode_e);
  assign hit[E_CONTEND] = rd_mode & drv_en;

  psram_write_timer #(.TW(TW), .T_PWE(T_PWE), .T_SCE(T_SCE), .T_BW(T_BW)) u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
    .err_pulse(hit[E_WPULSE]), .err_ce(hit[E_CE2END]), .err_be(hit[E_BE2END])
  );

  psram_read_watch #(.AW(AW), .TW(TW), .T_RC(T_RC), .T_ABN(T_ABN)) u_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .rd_mode(rd_mode),
    .addr(addr), .err_rdaddr(hit[E_RDADDR]), .err_abn(hit[E_ABNRD])
  );

  psram_err_log #(.NE(NUM_ERR), .CNT_W(CNT_W)) u_log (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clear(err_clear),
    .sticky(err_sticky), .count(viol_count)
  );
endmodule

// File: rtl/psram_bus_monitor_sva.sv
module psram_bus_monitor_sva #(
  parameter int NE    = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             we_n,
  input logic             ub_n,
  input logic             lb_n,
  input logic             drv_en,
  input logic             err_clear,
  input logic [2:0]       mode,
  input logic [NE-1:0]    err_sticky,
  input logic [CNT_W-1:0] viol_count
);
  assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || (ub_n && lb_n)) |-> mode == 3'd0);

  assert_write_low_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && !lb_n && ub_n) |-> mode == 3'd6);

  assert_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3 || mode == 3'd4) && drv_en) |=> err_sticky[0]);

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clear |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  assert_count_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> viol_count >= $past(viol_count));

  assert_count_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_count == '1) |=> viol_count == '1);
endmodule

bind psram_bus_monitor psram_bus_monitor_sva #(.NE(6), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
  .drv_en(drv_en), .err_clear(err_clear), .mode(mode), .err_sticky(err_sticky),
  .viol_count(viol_count)
);

// File: tb/test_psram_bus_monitor.sv
module test_psram_bus_monitor;
  localparam int AW = 17;
  localparam int NE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ce_n = 1, we_n = 1, oe_n = 1, ub_n = 1, lb_n = 1, drv_en = 0, err_clear = 0;
  logic [AW-1:0] addr = '0;
  logic [2:0]    mode;
  logic [NE-1:0] err_sticky;
  logic [15:0]   viol_count;
  int vecs = 0, bad = 0;
  int unsigned exp_cnt = 0;
  logic done = 0;

  psram_bus_monitor #(.AW(AW), .T_ABN(40)) i_psram_bus_monitor (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n),
    .lb_n(lb_n), .addr(addr), .drv_en(drv_en), .err_clear(err_clear),
    .mode(mode), .err_sticky(err_sticky), .viol_count(viol_count)
  );

  function automatic logic [2:0] exp_mode(logic ce, logic we, logic oe, logic ub, logic lb);
    logic [2:0] base;
    if (ce || (ub && lb)) return 3'd0;
    if (we && oe) return 3'd1;
    base = we ? 3'd2 : 3'd5;
    if (!ub && !lb) return base;
    if (!lb) return base + 3'd1;
    return base + 3'd2;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(logic ce, logic we, logic oe, logic ub, logic lb);
    ce_n = ce; we_n = we; oe_n = oe; ub_n = ub; lb_n = lb;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(int n);
    bus(1, 1, 1, 1, 1); cyc(n);
  endtask

  task automatic clr();
    err_clear = 1; cyc(1); err_clear = 0;
  endtask

  task automatic toggle(int n);
    repeat (n) begin addr = addr + 1'b1; cyc(1); end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic exp_c;
    void'($urandom(32'h5EED_0A17));
    cyc(4); rst_n = 1; cyc(1);
    chk("R9 reset sticky", 32'(err_sticky), 0);
    chk("R10 reset count", 32'(viol_count), 0);
    chk("R1 standby on ce high", 32'(mode), 0);
    bus(1, 0, 0, 0, 0); #1 chk("R1 ce high dominates", 32'(mode), 0);
    bus(0, 1, 0, 1, 1); #1 chk("R1 no lane is standby", 32'(mode), 0);
    idle(8);

    // R3 contention in read, ignored in outputs-disabled
    bus(0, 1, 0, 1, 0); drv_en = 1; cyc(1); drv_en = 0; exp_cnt++;
    chk("R3 contention flag", 32'(err_sticky), 32'h01);
    idle(3);
    chk("R9 sticky holds", 32'(err_sticky), 32'h01);
    clr();
    chk("R9 clear", 32'(err_sticky), 0);
    bus(0, 1, 1, 1, 0); drv_en = 1; cyc(2); drv_en = 0;
    chk("R3 drive ignored when outputs disabled", 32'(err_sticky), 0);
    bus(0, 1, 0, 0, 0); drv_en = 1; err_clear = 1; cyc(1);
    drv_en = 0; err_clear = 0; exp_cnt++;
    chk("R9 hit wins over clear", 32'(err_sticky), 32'h01);
    chk("R10 count", 32'(viol_count), exp_cnt);
    idle(8); clr();

    // write timing
    bus(0, 0, 1, 1, 0); cyc(6); idle(8);
    chk("R4 clean write", 32'(err_sticky), 0);
    bus(0, 1, 1, 1, 0); cyc(2); bus(0, 0, 1, 1, 0); cyc(3); idle(8); exp_cnt++;
    chk("R4 short we pulse", 32'(err_sticky), 32'h02);
    clr();
    bus(1, 0, 1, 1, 0); cyc(2); bus(0, 0, 1, 1, 0); cyc(4); bus(1, 0, 1, 1, 0); cyc(1);
    idle(8); exp_cnt++;
    chk("R5 short ce to write end", 32'(err_sticky), 32'h04);
    clr();
    bus(0, 0, 1, 1, 1); cyc(2); bus(0, 0, 1, 1, 0); cyc(4); bus(0, 0, 1, 1, 1); cyc(1);
    idle(8); exp_cnt++;
    chk("R6 short lane enable to write end", 32'(err_sticky), 32'h08);
    clr();
    bus(0, 0, 0, 0, 0); cyc(3); idle(8); exp_cnt += 3;
    chk("R4 R5 R6 all short", 32'(err_sticky), 32'h0E);
    chk("R10 multi-bit count", 32'(viol_count), exp_cnt);
    clr();

    // R7 address change during read
    bus(0, 1, 0, 1, 0); cyc(8); addr = addr + 17'd5; cyc(1);
    chk("R7 change after full read", 32'(err_sticky), 0);
    cyc(1); addr = addr + 17'd9; cyc(1); exp_cnt++;
    chk("R7 change mid read", 32'(err_sticky), 32'h10);
    idle(8); clr();

    // R8 abnormal read run
    bus(0, 1, 1, 1, 0); toggle(39);
    chk("R8 below run length", 32'(err_sticky), 0);
    toggle(1); exp_cnt++;
    chk("R8 run length reached", 32'(err_sticky), 32'h20);
    idle(8); clr();
    bus(0, 1, 1, 1, 0); toggle(30); cyc(8); toggle(30);
    chk("R8 restart on held address", 32'(err_sticky), 0);
    idle(8);
    bus(0, 1, 1, 1, 0); toggle(30); idle(8); bus(0, 1, 1, 1, 0); toggle(30);
    chk("R8 restart on long ce high", 32'(err_sticky), 0);
    idle(8);
    bus(0, 1, 1, 1, 0); toggle(30); idle(3); bus(0, 1, 1, 1, 0); toggle(12); exp_cnt++;
    chk("R8 short ce high only pauses", 32'(err_sticky), 32'h20);
    idle(8);
    chk("R10 count after directed", 32'(viol_count), exp_cnt);

    // random: mode decode and contention each cycle
    err_clear = 1;
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] r;
      logic [2:0] em;
      r = 6'($urandom);
      bus(r[0] & r[5], r[1], r[2], r[3], r[4]);
      drv_en = 1'($urandom);
      addr = AW'($urandom);
      em = exp_mode(ce_n, we_n, oe_n, ub_n, lb_n);
      exp_c = (em >= 3'd2 && em <= 3'd4) && drv_en;
      #1 chk(em >= 3'd5 ? "R2 write decode" : "R1 R2 decode", 32'(mode), 32'(em));
      cyc(1);
      chk("R3 random contention", 32'(err_sticky[0]), 32'(exp_c));
    end
    err_clear = 0; drv_en = 0; idle(8);

    // R10 saturation
    bus(0, 1, 0, 0, 0); drv_en = 1; cyc(66000); drv_en = 0; idle(2);
    chk("R10 saturated", 32'(viol_count), 32'hFFFF);
    clr();
    chk("R10 clear leaves count", 32'(viol_count), 32'hFFFF);

    done = 1;
    summary();
    $finish;
  end
endmodule